// File: doc/BRIEF.md
# Conditional Execution Pass Evaluator

This block decides whether a trapped 32-bit instruction would have executed under the processor's condition rules. It takes the exception syndrome word, a 4-bit condition code with a valid flag, and the program status word. The status word carries the four arithmetic flags and the split if-then block state. The block gives one pass/fail answer. Instruction decode and any update of the status word happen outside it.

The evaluation is tried in a fixed order. First, a syndrome with either of its top two bits set is unconditional. Next, a valid condition code is used directly. Last, when no valid code is supplied, the condition is rebuilt from the if-then state, and a zero state counts as unconditional. The chosen condition then selects a 16-bit truth mask, and the flags pick one bit of that mask. A combinational result is always available. A registered copy with one cycle of latency is offered beside it for callers that need a timing break.

Top module: `cond_pass_eval`

## Requirements
- R1: When syndrome[31] or syndrome[30] is 1, pass_comb is 1, whatever the other inputs are.
- R2: When cond_valid is 1 and cond is 4'hE, pass_comb is 1 for every flag value (unless R1 applies, in which case it is also 1).
- R3: When cond_valid is 1, cond is 4'hF and syndrome[31:30] is 0, pass_comb is 0 for every flag value.
- R4: With syndrome[31:30] zero and cond_valid 1, pass_comb equals bit F of the mask chosen by cond, where F = {psw[31] (N), psw[30] (Z), psw[29] (C), psw[28] (V)}. The masks for cond 0 through 15 are F0F0, 0F0F, CCCC, 3333, FF00, 00FF, AAAA, 5555, 0C0C, F3F3, AA55, 55AA, 0A05, F5FA, FFFF, 0000 (hex).
- R5: With syndrome[31:30] zero and cond_valid 0, an 8-bit if-then value is formed as {psw[15:10], psw[26:25]}. If that value is zero, pass_comb is 1. The cond input has no effect while cond_valid is 0.
- R6: With syndrome[31:30] zero, cond_valid 0 and a nonzero if-then value, the condition used for the R4 mask lookup is bits [7:4] of the if-then value, that is psw[15:12].
- R7: psw bits 27, 24:16 and 9:0 have no effect on pass_comb.
- R8: pass_q equals the pass_comb value of the previous clock cycle while rst is low.
- R9: A clock edge with rst high sets pass_q to 0 (synchronous reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered result |
| rst | input | 1 | Synchronous active-high reset of pass_q |
| syndrome | input | 32 | Trap syndrome word; top two bits flag unconditional |
| cond | input | 4 | Condition code from the trapped instruction |
| cond_valid | input | 1 | High when cond holds a usable condition |
| psw | input | 32 | Program status word: flags and if-then state |
| pass_comb | output | 1 | Combinational pass (1) / fail (0) |
| pass_q | output | 1 | pass_comb delayed by one clock |

## Verification
The bench builds the block with its defaults: mask table lookup (MASK_STYLE 0) and the registered output stage on (REG_OUT 1). With these settings both the combinational path and the one-cycle registered path can be checked against the same expected values. Every condition is swept over all sixteen flag combinations, and each result is compared with an independent flag-equation model. The if-then path is driven with single-bit state patterns and with random noise in the unused status bits. These show that the scattered field positions and the ignored bits behave as specified.

// File: rtl/cpe_pkg.sv
package cpe_pkg;

   localparam int COND_W  = 4;
   localparam int FLAGS_W = 4;
   localparam int MASK_W  = 1 << FLAGS_W;

   typedef logic [COND_W-1:0] cond_t;
   typedef logic [FLAGS_W-1:0] flags_t;
   typedef logic [MASK_W-1:0] mask_t;

   typedef enum logic [COND_W-1:0] {
      CC_ZSET = 4'h0, CC_ZCLR = 4'h1, CC_CSET = 4'h2, CC_CCLR = 4'h3,
      CC_NSET = 4'h4, CC_NCLR = 4'h5, CC_VSET = 4'h6, CC_VCLR = 4'h7,
      CC_UHI  = 4'h8, CC_ULS  = 4'h9, CC_SGE  = 4'hA, CC_SLT  = 4'hB,
      CC_SGT  = 4'hC, CC_SLE  = 4'hD, CC_ALL  = 4'hE, CC_NONE = 4'hF
   } cond_e;

   // Truth mask per condition; bit index is {N,Z,C,V}.
   function automatic mask_t cond_mask(input cond_t c);
      mask_t m;
      case (cond_e'(c))
         CC_ZSET: m = 16'hF0F0;
         CC_ZCLR: m = 16'h0F0F;
         CC_CSET: m = 16'hCCCC;
         CC_CCLR: m = 16'h3333;
         CC_NSET: m = 16'hFF00;
         CC_NCLR: m = 16'h00FF;
         CC_VSET: m = 16'hAAAA;
         CC_VCLR: m = 16'h5555;
         CC_UHI:  m = 16'h0C0C;
         CC_ULS:  m = 16'hF3F3;
         CC_SGE:  m = 16'hAA55;
         CC_SLT:  m = 16'h55AA;
         CC_SGT:  m = 16'h0A05;
         CC_SLE:  m = 16'hF5FA;
         CC_ALL:  m = 16'hFFFF;
         default: m = 16'h0000;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/cpe_uncond_dec.sv
module cpe_uncond_dec #(
   parameter int SYN_W       = 32,
   parameter int UNCOND_BITS = 2
) (
   input  logic [SYN_W-1:0] syndrome,
   output logic             uncond
);
   localparam int TOP_LSB = SYN_W - UNCOND_BITS;

   generate
      if (UNCOND_BITS < 1 || UNCOND_BITS > SYN_W) begin : g_bad_cfg
         $error("cpe_uncond_dec: UNCOND_BITS out of range");
      end
   endgenerate

   logic [UNCOND_BITS-1:0] top_bits;

   always_comb begin
      top_bits = syndrome[SYN_W-1:TOP_LSB];
      uncond   = |top_bits;
   end
endmodule

// File: rtl/cpe_it_recover.sv
module cpe_it_recover #(
   parameter int PSW_W     = 32,
   parameter int IT_HI_LSB = 10,
   parameter int IT_HI_W   = 6,
   parameter int IT_LO_LSB = 25,
   parameter int IT_LO_W   = 2
) (
   input  logic [PSW_W-1:0]        psw,
   output logic                    it_zero,
   output cpe_pkg::cond_t          it_cond
);
   import cpe_pkg::*;

   localparam int IT_W = IT_HI_W + IT_LO_W;

   generate
      if (IT_W < COND_W) begin : g_bad_width
         $error("cpe_it_recover: if-then value narrower than a condition");
      end
      if (IT_HI_LSB + IT_HI_W > PSW_W || IT_LO_LSB + IT_LO_W > PSW_W) begin : g_bad_pos
         $error("cpe_it_recover: if-then field outside status word");
      end
   endgenerate

   logic [IT_W-1:0] it_val;

   always_comb begin
      it_val  = {psw[IT_HI_LSB +: IT_HI_W], psw[IT_LO_LSB +: IT_LO_W]};
      it_zero = (it_val == '0);
      it_cond = it_val[IT_W-1 -: COND_W];
   end
endmodule

// File: rtl/cpe_mask_eval.sv
module cpe_mask_eval #(
   parameter int MASK_STYLE = 0
) (
   input  cpe_pkg::cond_t  cond,
   input  cpe_pkg::flags_t flags,
   output logic            hit
);
   import cpe_pkg::*;

   generate
      if (MASK_STYLE == 0) begin : g_table
         mask_t m;
         always_comb begin
            m   = cond_mask(cond);
            hit = m[flags];
         end
      end else if (MASK_STYLE == 1) begin : g_equation
         logic fn, fz, fc, fv, base;
         always_comb begin
            {fn, fz, fc, fv} = flags;
            case (cond[COND_W-1:1])
               3'd0:    base = fz;
               3'd1:    base = fc;
               3'd2:    base = fn;
               3'd3:    base = fv;
               3'd4:    base = fc & ~fz;
               3'd5:    base = (fn == fv);
               3'd6:    base = ~fz & (fn == fv);
               default: base = 1'b1;
            endcase
            hit = base ^ cond[0];
         end
      end else begin : g_bad_style
         $error("cpe_mask_eval: MASK_STYLE must be 0 or 1");
      end
   endgenerate
endmodule

// File: rtl/cpe_out_stage.sv
module cpe_out_stage #(
   parameter bit REG_OUT = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   generate
      if (REG_OUT) begin : g_reg
         logic q_r;
         always_ff @(posedge clk) begin
            if (rst) q_r <= 1'b0;
            else     q_r <= d;
         end
         assign q = q_r;

         AST_REG_FOLLOW: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (q == $past(d))) else $error("AST_REG_FOLLOW"); // R8
      end else begin : g_pass
         assign q = d;
      end
   endgenerate
endmodule

// File: rtl/cond_pass_eval.sv
module cond_pass_eval #(
   parameter int SYN_W       = 32,
   parameter int UNCOND_BITS = 2,
   parameter int PSW_W       = 32,
   parameter int FLAG_LSB    = 28,
   parameter int IT_HI_LSB   = 10,
   parameter int IT_LO_LSB   = 25,
   parameter int MASK_STYLE  = 0,
   parameter bit REG_OUT     = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SYN_W-1:0] syndrome,
   input  logic [3:0]       cond,
   input  logic             cond_valid,
   input  logic [PSW_W-1:0] psw,
   output logic             pass_comb,
   output logic             pass_q
);
   import cpe_pkg::*;

   generate
      if (FLAG_LSB + FLAGS_W > PSW_W) begin : g_bad_flags
         $error("cond_pass_eval: flag field outside status word");
      end
   endgenerate

   logic   uncond;
   logic   it_zero;
   cond_t  it_cond;
   cond_t  eff_cond;
   flags_t flags;
   logic   mask_hit;

   cpe_uncond_dec #(.SYN_W(SYN_W), .UNCOND_BITS(UNCOND_BITS)) u_uncond (
      .syndrome (syndrome),
      .uncond   (uncond)
   );

   cpe_it_recover #(.PSW_W(PSW_W), .IT_HI_LSB(IT_HI_LSB), .IT_HI_W(6),
                    .IT_LO_LSB(IT_LO_LSB), .IT_LO_W(2)) u_it (
      .psw     (psw),
      .it_zero (it_zero),
      .it_cond (it_cond)
   );

   always_comb begin
      flags    = psw[FLAG_LSB +: FLAGS_W];
      eff_cond = cond_valid ? cond : it_cond;
   end

   cpe_mask_eval #(.MASK_STYLE(MASK_STYLE)) u_mask (
      .cond  (eff_cond),
      .flags (flags),
      .hit   (mask_hit)
   );

   always_comb begin
      if (uncond)                               pass_comb = 1'b1;
      else if (cond_valid && cond == CC_ALL)    pass_comb = 1'b1;
      else if (!cond_valid && it_zero)          pass_comb = 1'b1;
      else                                      pass_comb = mask_hit;
   end

   cpe_out_stage #(.REG_OUT(REG_OUT)) u_out (
      .clk (clk),
      .rst (rst),
      .d   (pass_comb),
      .q   (pass_q)
   );

   AST_UNCOND_PASS: assert property (@(posedge clk) disable iff (rst)
      (syndrome[SYN_W-1 -: UNCOND_BITS] != '0) |-> pass_comb) else $error("AST_UNCOND_PASS"); // R1
   AST_ALWAYS_PASS: assert property (@(posedge clk) disable iff (rst)
      (cond_valid && cond == 4'hE) |-> pass_comb) else $error("AST_ALWAYS_PASS"); // R2
   AST_NEVER_FAIL: assert property (@(posedge clk) disable iff (rst)
      (cond_valid && cond == 4'hF && syndrome[SYN_W-1 -: UNCOND_BITS] == '0) |-> !pass_comb)
      else $error("AST_NEVER_FAIL"); // R3
   AST_IT_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
      (!cond_valid && psw[IT_HI_LSB +: 6] == '0 && psw[IT_LO_LSB +: 2] == '0) |-> pass_comb)
      else $error("AST_IT_ZERO_PASS"); // R5
endmodule

// File: tb/cond_pass_eval_tb_top.sv
module cond_pass_eval_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] syndrome = 32'hC000_0000;
   logic [3:0]  cond = 4'hF;
   logic        cond_valid = 1'b1;
   logic [31:0] psw = 32'h0;
   logic        pass_comb, pass_q;

   int nchk = 0;
   int nerr = 0;
   bit done = 0;

   logic  exp_q[$];
   string tag_q[$];

   localparam logic [31:0] JUNK_MASK = (32'h1 << 27) | (32'h1FF << 16) | 32'h3FF;

   cond_pass_eval dut_i (
      .clk(clk), .rst(rst), .syndrome(syndrome), .cond(cond),
      .cond_valid(cond_valid), .psw(psw), .pass_comb(pass_comb), .pass_q(pass_q)
   );

   always #4 clk = ~clk;

   // Reference: flag equations per condition.
   function automatic logic ref_flag(input logic [3:0] c, input logic n, z, cy, v);
      case (c)
         4'd0:  return z;
         4'd1:  return !z;
         4'd2:  return cy;
         4'd3:  return !cy;
         4'd4:  return n;
         4'd5:  return !n;
         4'd6:  return v;
         4'd7:  return !v;
         4'd8:  return cy && !z;
         4'd9:  return !cy || z;
         4'd10: return n == v;
         4'd11: return n != v;
         4'd12: return !z && (n == v);
         4'd13: return z || (n != v);
         4'd14: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic ref_pass(input logic [31:0] s, input logic [3:0] c,
                                     input logic vld, input logic [31:0] p);
      logic [7:0] itv;
      logic [3:0] ec;
      if (s[31] || s[30]) return 1'b1;
      if (vld) ec = c;
      else begin
         itv = {p[15:10], p[26:25]};
         if (itv == 8'h00) return 1'b1;
         ec = itv[7:4];
      end
      return ref_flag(ec, p[31], p[30], p[29], p[28]);
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   // Driver: apply one input vector, check comb result, queue the registered expectation.
   task automatic apply(input string req, input logic [31:0] s, input logic [3:0] c,
                        input logic vld, input logic [31:0] p);
      logic e;
      @(negedge clk);
      syndrome = s; cond = c; cond_valid = vld; psw = p;
      #1;
      e = ref_pass(s, c, vld, p);
      chk(req, pass_comb, e);
      exp_q.push_back(e);
      tag_q.push_back({req, "/R8"});
   endtask

   // Monitor: registered output one clock after the driver's vector.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (!rst && exp_q.size() > 0) chk(tag_q.pop_front(), pass_q, exp_q.pop_front());
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1;
         nerr++; nchk++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      // R9: reset with passing inputs holds pass_q low
      repeat (2) @(posedge clk);
      #3;
      chk("R9", pass_q, 1'b0);
      @(negedge clk);
      rst = 1'b0;

      // R4/R2/R3: every condition against all flag values
      for (int c = 0; c < 16; c++) begin
         for (int f = 0; f < 16; f++) begin
            string t;
            t = (c == 14) ? "R2" : (c == 15) ? "R3" : "R4";
            apply(t, 32'h0000_0000, 4'(c), 1'b1, {4'(f), 28'h0});
         end
      end

      // R1: top syndrome bits force pass, even for never
      for (int s = 1; s < 4; s++) begin
         for (int f = 0; f < 16; f += 5) begin
            apply("R1", {2'(s), 30'h0}, 4'hF, 1'b1, {4'(f), 28'h0});
            apply("R1", {2'(s), 30'h1234}, 4'h0, 1'b0, {4'(f), 28'h0000_F000});
         end
      end

      // R5: zero if-then value passes, cond input ignored
      for (int f = 0; f < 16; f++)
         apply("R5", 32'h0, 4'(f), 1'b0, {4'(f), 28'h0});

      // R5/R6: single-bit if-then patterns check field positions
      apply("R6", 32'h0, 4'hE, 1'b0, 32'h0400_0000); // psw[26] -> it=02, cond EQ, Z=0 -> fail
      apply("R6", 32'h0, 4'hE, 1'b0, 32'h4400_0000); // Z=1 -> pass
      apply("R6", 32'h0, 4'hE, 1'b0, 32'h0200_0000); // psw[25]
      apply("R6", 32'h0, 4'hE, 1'b0, 32'h0000_0400); // psw[10]
      apply("R6", 32'h0, 4'hE, 1'b0, 32'h0000_0800); // psw[11]
      apply("R6", 32'h0, 4'hE, 1'b0, 32'h0000_F000); // cond NV -> fail

      // R6: every recovered condition with all flags, low it bits nonzero
      for (int c = 0; c < 16; c++)
         for (int f = 0; f < 16; f++)
            apply("R6", 32'h0, 4'hE, 1'b0, {4'(f), 1'b0, 2'b01, 9'h0, 4'(c), 2'b00, 10'h0});

      // R7: noise in unused status bits has no effect
      for (int i = 0; i < 200; i++) begin
         logic [31:0] base, junk;
         base = $urandom & ~JUNK_MASK;
         junk = $urandom & JUNK_MASK;
         apply("R7", {2'b00, 30'($urandom)}, 4'($urandom), 1'($urandom), base | junk);
      end

      // R9: mid-run reset clears pass_q despite passing inputs
      @(negedge clk);
      rst = 1'b1;
      syndrome = 32'hC000_0000;
      @(posedge clk);
      #3;
      chk("R9", pass_q, 1'b0);
      @(negedge clk);
      rst = 1'b0;
      apply("R8", 32'h0, 4'h0, 1'b1, 32'h4000_0000);
      apply("R8", 32'h0, 4'h0, 1'b1, 32'h0000_0000);
      repeat (2) @(posedge clk);
      #3;

      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule